// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Cycle Sequencer

This block is a register-programmed master for a single-lane SPI flash. Software fills a menu of eight one-byte opcodes and gives each entry a 2-bit cycle kind. It also loads a 24-bit flash address and up to 64 bytes into a data buffer. A single control write then starts a cycle. The control word carries the menu index, the byte count, a data enable, a clock-rate choice and an optional atomic prefix. The sequencer shifts the opcode out, then the address if the kind carries one, then the data, using SPI mode 0.

When atomic mode is requested, the stored prefix opcode (normally a write-enable) goes out first as a frame of its own. Chip select rises for a short guard time, and the main frame follows with nothing able to start in between. Completion and rejected starts are reported through sticky status flags that software clears by writing ones. A lock bit freezes the menu, the kind table and the prefix until reset.

Registers sit on a plain word-wide bus. The bus write takes effect on the clock edge, and the read data is combinational from the address. The word addresses are: 0 control, 1 status, 2 flash address, 3 and 4 menu entries 0-3 and 4-7 (entry 4w+j in byte lane j), 5 kind table, 6 prefix opcode, and 16 to 31 the data buffer, with buffer byte 4w+j in lane j of word 16+w.

Top module: `spi_seq_top`

## Requirements
- R1: After reset, chip select is high, the SPI clock is low and the status word reads 0.
- R2: The go bit (control bit 0) starts a cycle whose first byte is the menu entry chosen by control bits 6:4, sent MSB first.
- R3: The kind of menu entry n is kind-table bits 2n+1:2n: 0 read without address, 1 write without address, 2 read with address, 3 write with address. Kinds 2 and 3 send flash-address bits 23:16, 15:8 and 7:0 after the opcode, and bits 31:24 are never sent.
- R4: When control bit 2 (data enable) is set, the frame carries N+1 data bytes, where N is control bits 13:8. When bit 2 is clear, the frame ends after the opcode and the address.
- R5: A read kind sends 0x00 on MOSI during the data bytes and stores the received bytes into the buffer from byte 0 in arrival order. A write kind sends buffer bytes from byte 0 upward and leaves the buffer unchanged.
- R6: Status bit 0 (busy) is 1 from the go write until the cycle ends. Status bit 1 (done) is set when a cycle ends. Writing 1 to status bit 1 or bit 2 clears that bit.
- R7: With control bit 1 (atomic) set, the prefix-opcode register is sent as a one-byte frame. Chip select then stays high for at least 2 SPI clock periods before the main frame starts.
- R8: Writing 1 to status bit 3 sets the lock, which then reads back as 1. While the lock is set, writes to the menu, the kind table and the prefix are ignored. Only reset clears the lock.
- R9: With control bit 3 clear, the SPI clock period is 2*DIV_SLOW system clocks. With bit 3 set, it is 2*DIV_FAST system clocks.
- R10: A go write while busy is ignored: the running frame is not altered, and status bit 2 (error) is set.
- R11: SPI mode 0 is used. The clock idles low while chip select is high, MOSI changes on falling edges and MISO is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps every menu index against all four kinds. A wrong index or kind decode would send the wrong opcode or the wrong frame length. It runs a full 64-byte write at the fast rate and a short read at the slow rate. These catch an off-by-one count, a wrong clock divider, or read data landing at the wrong buffer offset or spilling past the last byte. It also checks that the upper address byte is never sent. The atomic prefix is checked for a separate frame and a wide enough guard gap. A go issued during a cycle must raise the error flag without disturbing the frame in flight. Once locked, writes to the menu and the prefix must leave both unchanged.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int DATA_BYTES = 64;
  localparam int CNT_W      = $clog2(DATA_BYTES);
  localparam int LEN_W      = CNT_W + 1;
  localparam int MENU_N     = 8;
  localparam int IDX_W      = $clog2(MENU_N);
  localparam int MENU_WORDS = MENU_N / 4;
  localparam int DWORDS     = DATA_BYTES / 4;
  localparam int DW_W       = $clog2(DWORDS);
  localparam int AW         = DW_W + 1;
  localparam int ADDR_BYTES = 3;

  // register word offsets
  localparam int RA_CTRL   = 0;
  localparam int RA_STATUS = 1;
  localparam int RA_FADDR  = 2;
  localparam int RA_MENU0  = 3;
  localparam int RA_KINDS  = RA_MENU0 + MENU_WORDS;
  localparam int RA_PREFIX = RA_KINDS + 1;

  // control bit positions
  localparam int CB_GO   = 0;
  localparam int CB_ATOM = 1;
  localparam int CB_DEN  = 2;
  localparam int CB_FAST = 3;
  localparam int CB_IDX  = 4;
  localparam int CB_CNT  = 8;
  localparam int CTRL_W  = CB_CNT + CNT_W;

  typedef enum logic [1:0] {
    KIND_RD     = 2'd0,
    KIND_WR     = 2'd1,
    KIND_RD_ADR = 2'd2,
    KIND_WR_ADR = 2'd3
  } cyc_kind_e;

  function automatic logic [LEN_W-1:0] hdr_bytes(logic [1:0] kind);
    return kind[1] ? LEN_W'(1 + ADDR_BYTES) : LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] frame_bytes(logic [1:0] kind, logic den,
                                                   logic [CNT_W-1:0] cnt);
    return hdr_bytes(kind) + (den ? (LEN_W'(cnt) + LEN_W'(1)) : LEN_W'(0));
  endfunction

  function automatic logic [7:0] addr_byte(logic [23:0] fa, logic [LEN_W-1:0] k);
    case (k)
      LEN_W'(1): return fa[23:16];
      LEN_W'(2): return fa[15:8];
      default:   return fa[7:0];
    endcase
  endfunction
endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
  parameter int DIV_SLOW = 5,
  parameter int DIV_FAST = 3,
  parameter int DIV_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = fast ? DIV_W'(DIV_FAST - 1) : DIV_W'(DIV_SLOW - 1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       tick,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       byte_done
);
  logic       active_q;
  logic [7:0] tx_q;
  logic [2:0] bit_q;

  assign byte_done = active_q && tick && sck && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      tx_q     <= '0;
      rx       <= '0;
      bit_q    <= '0;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      sck      <= 1'b0;
      mosi     <= tx[7];
      tx_q     <= {tx[6:0], 1'b0};
      bit_q    <= '0;
    end else if (active_q && tick) begin
      if (!sck) begin
        sck <= 1'b1;
        rx  <= {rx[6:0], miso};
      end else begin
        sck <= 1'b0;
        if (bit_q == 3'd7) begin
          active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          mosi  <= tx_q[7];
          tx_q  <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 busy,
  input  logic                 set_done,
  input  logic                 set_err,
  input  logic                 eng_we,
  input  logic [CNT_W-1:0]     eng_idx,
  input  logic [7:0]           eng_wbyte,
  output logic [7:0]           eng_rbyte,
  output logic                 go_req,
  output logic [IDX_W-1:0]     go_idx,
  output logic [CNT_W-1:0]     go_cnt,
  output logic                 go_den,
  output logic                 go_fast,
  output logic                 go_atom,
  output logic [7:0]           go_opc,
  output logic [1:0]           go_kind,
  output logic [7:0]           prefix_opc,
  output logic [23:0]          flash_addr,
  output logic                 lock,
  output logic                 done_flag,
  output logic                 err_flag
);
  logic [CTRL_W-1:0]     ctrl_q;
  logic [31:0]           faddr_q;
  logic [8*MENU_N-1:0]   menu_flat;
  logic [2*MENU_N-1:0]   kinds_q;
  logic [7:0]            dbuf [DATA_BYTES];

  logic wr_ctrl, wr_status, wr_data;
  assign wr_ctrl   = reg_wr && (int'(reg_addr) == RA_CTRL);
  assign wr_status = reg_wr && (int'(reg_addr) == RA_STATUS);
  assign wr_data   = reg_wr && reg_addr[AW-1];

  assign go_req  = wr_ctrl && reg_wdata[CB_GO];
  assign go_idx  = reg_wdata[CB_IDX +: IDX_W];
  assign go_cnt  = reg_wdata[CB_CNT +: CNT_W];
  assign go_den  = reg_wdata[CB_DEN];
  assign go_fast = reg_wdata[CB_FAST];
  assign go_atom = reg_wdata[CB_ATOM];
  assign go_opc  = menu_flat[8*int'(go_idx) +: 8];
  assign go_kind = kinds_q[2*int'(go_idx) +: 2];
  assign flash_addr = faddr_q[23:0];
  assign eng_rbyte  = dbuf[eng_idx];

  // menu entries, one register each
  for (genvar n = 0; n < MENU_N; n++) begin : g_menu
    logic [7:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else if (reg_wr && !lock && (int'(reg_addr) == RA_MENU0 + n / 4))
        ent_q <= reg_wdata[8*(n%4) +: 8];
    end
    assign menu_flat[8*n +: 8] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      faddr_q    <= '0;
      kinds_q    <= '0;
      prefix_opc <= '0;
      lock       <= 1'b0;
      done_flag  <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (wr_ctrl && !busy) ctrl_q <= {reg_wdata[CTRL_W-1:1], 1'b0};
      if (reg_wr && int'(reg_addr) == RA_FADDR) faddr_q <= reg_wdata;
      if (reg_wr && !lock && int'(reg_addr) == RA_KINDS)
        kinds_q <= reg_wdata[2*MENU_N-1:0];
      if (reg_wr && !lock && int'(reg_addr) == RA_PREFIX)
        prefix_opc <= reg_wdata[7:0];
      if (wr_status && reg_wdata[3]) lock <= 1'b1;
      if (set_done) done_flag <= 1'b1;
      else if (wr_status && reg_wdata[1]) done_flag <= 1'b0;
      if (set_err) err_flag <= 1'b1;
      else if (wr_status && reg_wdata[2]) err_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_BYTES; i++) dbuf[i] <= '0;
    end else if (eng_we) begin
      dbuf[eng_idx] <= eng_wbyte;
    end else if (wr_data) begin
      for (int l = 0; l < 4; l++)
        dbuf[{reg_addr[DW_W-1:0], 2'(l)}] <= reg_wdata[8*l +: 8];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1]) begin
      for (int l = 0; l < 4; l++)
        reg_rdata[8*l +: 8] = dbuf[{reg_addr[DW_W-1:0], 2'(l)}];
    end else begin
      if (int'(reg_addr) == RA_CTRL)   reg_rdata[CTRL_W-1:0] = ctrl_q;
      if (int'(reg_addr) == RA_STATUS) reg_rdata[3:0] = {lock, err_flag, done_flag, busy};
      if (int'(reg_addr) == RA_FADDR)  reg_rdata = faddr_q;
      for (int w = 0; w < MENU_WORDS; w++)
        if (int'(reg_addr) == RA_MENU0 + w) reg_rdata = menu_flat[32*w +: 32];
      if (int'(reg_addr) == RA_KINDS)  reg_rdata[2*MENU_N-1:0] = kinds_q;
      if (int'(reg_addr) == RA_PREFIX) reg_rdata[7:0] = prefix_opc;
    end
  end
endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
  import spi_seq_pkg::*;
#(
  parameter int DIV_SLOW  = 5,
  parameter int DIV_FAST  = 3,
  parameter int GAP_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int DIV_W = $clog2((DIV_SLOW > DIV_FAST ? DIV_SLOW : DIV_FAST) + 1);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} seq_state_e;
  seq_state_e state_q;

  // named internal events
  logic busy, go_req, go_take, go_reject, cycle_end, lock, done_flag, err_flag;
  logic tick, byte_done, eng_we;

  logic [IDX_W-1:0] go_idx;
  logic [CNT_W-1:0] go_cnt;
  logic go_den, go_fast, go_atom;
  logic [7:0] go_opc, prefix_opc, eng_rbyte, rx_byte, tx_byte;
  logic [1:0] go_kind;
  logic [23:0] flash_addr;

  logic [7:0]       opc_q, pre_opc_q;
  logic [1:0]       kind_q;
  logic [LEN_W-1:0] len_q, hdr_q, k_q;
  logic             pre_q, fast_q;
  logic [23:0]      fa_q;
  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] data_idx;

  assign busy      = (state_q != ST_IDLE);
  assign go_take   = go_req && !busy;
  assign go_reject = go_req && busy;
  assign cycle_end = (state_q == ST_SHIFT) && byte_done && !pre_q && (k_q == len_q - 1'b1);
  assign data_idx  = CNT_W'(k_q - hdr_q);
  assign eng_we    = (state_q == ST_SHIFT) && byte_done && !pre_q &&
                     (k_q >= hdr_q) && !kind_q[0];
  assign spi_cs_n  = !((state_q == ST_LOAD) || (state_q == ST_SHIFT));

  spi_seq_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .busy, .set_done(cycle_end), .set_err(go_reject),
    .eng_we, .eng_idx(data_idx), .eng_wbyte(rx_byte), .eng_rbyte,
    .go_req, .go_idx, .go_cnt, .go_den, .go_fast, .go_atom, .go_opc, .go_kind,
    .prefix_opc, .flash_addr, .lock, .done_flag, .err_flag
  );

  spi_seq_clkgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .DIV_W(DIV_W)) u_clk (
    .clk, .rst_n,
    .run((state_q == ST_SHIFT) || (state_q == ST_GAP)),
    .fast(fast_q), .tick
  );

  spi_seq_shifter u_shift (
    .clk, .rst_n, .start(state_q == ST_LOAD), .tx(tx_byte), .tick,
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .rx(rx_byte), .byte_done
  );

  always_comb begin
    tx_byte = 8'h00;
    if (pre_q)                 tx_byte = pre_opc_q;
    else if (k_q == '0)        tx_byte = opc_q;
    else if (k_q < hdr_q)      tx_byte = addr_byte(fa_q, k_q);
    else if (kind_q[0])        tx_byte = eng_rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      opc_q     <= '0;
      pre_opc_q <= '0;
      kind_q    <= '0;
      len_q     <= '0;
      hdr_q     <= '0;
      k_q       <= '0;
      pre_q     <= 1'b0;
      fast_q    <= 1'b0;
      fa_q      <= '0;
      gap_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_take) begin
          opc_q     <= go_opc;
          pre_opc_q <= prefix_opc;
          kind_q    <= go_kind;
          hdr_q     <= hdr_bytes(go_kind);
          len_q     <= frame_bytes(go_kind, go_den, go_cnt);
          pre_q     <= go_atom;
          fast_q    <= go_fast;
          fa_q      <= flash_addr;
          k_q       <= '0;
          state_q   <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_SHIFT;
        ST_SHIFT: if (byte_done) begin
          if (pre_q) begin
            pre_q   <= 1'b0;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end else if (k_q == len_q - 1'b1) begin
            state_q <= ST_IDLE;
          end else begin
            k_q     <= k_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q == GAP_W'(GAP_TICKS - 1)) state_q <= ST_LOAD;
          else gap_q <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic cycle_end,
  input logic go_reject,
  input logic lock,
  input logic done_flag,
  input logic err_flag,
  input logic spi_cs_n,
  input logic spi_sck
);
  a_r1_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  a_r11_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  a_r6_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> done_flag);
  a_r6_busy_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !busy);
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_end) |=> busy);
  a_r10_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    go_reject |=> err_flag);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
endmodule

bind spi_seq_top spi_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cycle_end(cycle_end),
  .go_reject(go_reject), .lock(lock), .done_flag(done_flag),
  .err_flag(err_flag), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/tb_spi_seq_top.sv
module tb_spi_seq_top;
  localparam int DIV_SLOW = 5;
  localparam int DIV_FAST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_seq_top #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .spi_cs_n, .spi_sck, .spi_mosi, .spi_miso
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int p);
    return 8'hC3 ^ 8'(p * 29);
  endfunction

  // flash model and monitor
  int cyc = 0;
  always @(negedge clk) cyc++;
  logic [7:0] rec [0:255];
  int flen [0:7];
  int nbytes, nframes, pos, bitc, t_rise, t_csrise, gap_last, min_per;
  logic [7:0] shreg, mb;

  task automatic clear_mon();
    nbytes = 0; nframes = 0; min_per = 99999; gap_last = 0;
  endtask

  always @(negedge spi_cs_n) begin
    pos = 0; bitc = 0;
    gap_last = cyc - t_csrise;
    mb = pat(0);
    spi_miso = mb[7];
  end
  always @(posedge spi_cs_n) begin
    if (nframes < 8) flen[nframes] = pos;
    nframes++;
    t_csrise = cyc;
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (bitc != 0 && (cyc - t_rise) < min_per) min_per = cyc - t_rise;
    t_rise = cyc;
    shreg = {shreg[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (nbytes < 256) rec[nbytes] = shreg;
      nbytes++; pos++; bitc = 0;
    end
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    mb = pat(pos);
    spi_miso = mb[7 - bitc];
  end

  // bus tasks
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(1, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] mk(input int idx, input int cnt, input bit den,
                                     input bit fast, input bit atom);
    return 32'(1 | (int'(atom) << 1) | (int'(den) << 2) | (int'(fast) << 3) |
               (idx << 4) | (cnt << 8));
  endfunction

  logic [7:0] mem [0:63];
  logic [31:0] kinds_val;

  task automatic check_buf(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      rd(16 + w, d);
      chk(d == {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]}, tag, int'(d),
          int'({mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    t_csrise = 0; t_rise = 0; clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1, d);
    chk(d == 0, "R1 status after reset", int'(d), 0);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 idle lines", int'({spi_cs_n, spi_sck}), 2);

    // configuration: menu entry i = 0x40+i, kind i%4, buffer b^0x96
    wr(3, 32'h43424140);
    wr(4, 32'h47464544);
    kinds_val = '0;
    for (int i = 0; i < 8; i++) kinds_val |= 32'(i % 4) << (2 * i);
    wr(5, kinds_val);
    for (int w = 0; w < 16; w++) begin
      for (int l = 0; l < 4; l++) mem[4*w+l] = 8'((4*w+l) ^ 8'h96);
      wr(16 + w, {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]});
    end
    wr(2, 32'h00123456);

    // R2/R3/R4 sweep: every index, data disabled
    for (int i = 0; i < 8; i++) begin
      int exp_len;
      clear_mon();
      wr(0, mk(i, 5, 1'b0, 1'b0, 1'b0));
      wait_idle();
      exp_len = (i % 4 >= 2) ? 4 : 1;
      chk(nframes == 1 && flen[0] == exp_len, "R4 frame length without data", flen[0], exp_len);
      chk(rec[0] == 8'(8'h40 + i), "R2 opcode by index", int'(rec[0]), 8'h40 + i);
      if (exp_len == 4)
        chk({rec[1], rec[2], rec[3]} == 24'h123456, "R3 address bytes",
            int'({rec[1], rec[2], rec[3]}), 24'h123456);
    end
    wr(1, 32'h2);

    // R5/R9 read with address, 5 bytes, slow clock
    clear_mon();
    wr(2, 32'h000A0B0C);
    wr(0, mk(2, 4, 1'b1, 1'b0, 1'b0));
    wait_idle();
    chk(flen[0] == 9, "R4 read frame length", flen[0], 9);
    chk({rec[4], rec[5], rec[6], rec[7], rec[8]} == 40'h0, "R5 read sends zeros",
        int'(rec[4]), 0);
    for (int j = 0; j < 5; j++) mem[j] = pat(4 + j);
    check_buf("R5 read data stored from byte 0");
    chk(min_per == 2 * DIV_SLOW, "R9 slow SCK period", min_per, 2 * DIV_SLOW);
    rd(1, d);
    chk(d == 32'h2, "R6 done set after cycle", int'(d), 2);
    wr(1, 32'h2);
    rd(1, d);
    chk(d == 32'h0, "R6 done cleared by write-one", int'(d), 0);

    // R5/R9 write with address, 64 bytes, fast clock
    clear_mon();
    wr(0, mk(3, 63, 1'b1, 1'b1, 1'b0));
    wait_idle();
    chk(flen[0] == 68, "R4 64-byte frame length", flen[0], 68);
    begin
      int bad = 0;
      for (int j = 0; j < 64; j++) if (rec[4 + j] != mem[j]) bad++;
      chk(bad == 0, "R5 write data order", bad, 0);
    end
    check_buf("R5 buffer unchanged by write");
    chk(min_per == 2 * DIV_FAST, "R9 fast SCK period", min_per, 2 * DIV_FAST);
    wr(1, 32'h2);

    // R3 upper address byte never sent
    clear_mon();
    wr(2, 32'hFFABCDEF);
    wr(0, mk(6, 0, 1'b0, 1'b0, 1'b0));
    wait_idle();
    chk(flen[0] == 4 && {rec[1], rec[2], rec[3]} == 24'hABCDEF, "R3 low 24 address bits",
        int'({rec[1], rec[2], rec[3]}), 24'hABCDEF);

    // R5 read without address, 2 bytes
    clear_mon();
    wr(0, mk(4, 1, 1'b1, 1'b0, 1'b0));
    wait_idle();
    chk(flen[0] == 3 && rec[0] == 8'h44, "R3 read without address frame", flen[0], 3);
    mem[0] = pat(1); mem[1] = pat(2);
    check_buf("R5 read no-address data");
    wr(1, 32'h2);

    // R7 atomic prefix
    clear_mon();
    wr(6, 32'h06);
    wr(0, mk(5, 0, 1'b0, 1'b0, 1'b1));
    wait_idle();
    chk(nframes == 2, "R7 two frames", nframes, 2);
    chk(flen[0] == 1 && rec[0] == 8'h06, "R7 prefix frame", int'(rec[0]), 6);
    chk(flen[1] == 1 && rec[1] == 8'h45, "R7 main frame after prefix", int'(rec[1]), 8'h45);
    chk(gap_last >= 4 * DIV_SLOW, "R7 chip-select gap", gap_last, 4 * DIV_SLOW);
    wr(1, 32'h2);

    // R10 go while busy
    clear_mon();
    wr(0, mk(3, 15, 1'b1, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    rd(1, d);
    chk(d[0] == 1'b1, "R6 busy during cycle", int'(d), 1);
    wr(0, mk(0, 0, 1'b0, 1'b0, 1'b0));
    wait_idle();
    chk(nframes == 1 && flen[0] == 20 && rec[0] == 8'h43, "R10 running frame unaltered",
        flen[0], 20);
    rd(1, d);
    chk(d == 32'h6, "R10 error set", int'(d), 6);
    wr(1, 32'h6);
    rd(1, d);
    chk(d == 32'h0, "R6 error cleared by write-one", int'(d), 0);

    // R8 lock
    wr(1, 32'h8);
    rd(1, d);
    chk(d == 32'h8, "R8 lock reads back", int'(d), 8);
    wr(3, 32'hFFFFFFFF);
    rd(3, d);
    chk(d == 32'h43424140, "R8 menu write ignored", int'(d), 32'h43424140);
    wr(5, 32'h0);
    rd(5, d);
    chk(d == kinds_val, "R8 kind write ignored", int'(d), int'(kinds_val));
    wr(6, 32'h99);
    rd(6, d);
    chk(d == 32'h06, "R8 prefix write ignored", int'(d), 6);
    clear_mon();
    wr(0, mk(1, 0, 1'b0, 1'b0, 1'b0));
    wait_idle();
    chk(flen[0] == 1 && rec[0] == 8'h41, "R8 locked menu still used", int'(rec[0]), 8'h41);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1, d);
    chk(d == 32'h0, "R8 lock cleared by reset", int'(d), 0);
    rd(3, d);
    chk(d == 32'h0, "R1 menu reset", int'(d), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule